// File: doc/BRIEF.md
# Multi-Source Supervisor Reset Generator

This block turns a set of digitized supply-monitor flags and a push-button input into a clean system reset. A drop of the main supply forces reset in the same cycle. A manual press forces reset once the debouncer has accepted it. When every cause has gone away, reset is held for a selectable number of clock cycles, counted from the release of the last active cause. Both reset polarities are driven.

The supply flags come straight from comparators. They are treated as already synchronous, and they also feed three warning outputs that have no hold delay: an early low-supply flag and two auxiliary fail flags. The push-button pin is asynchronous. It is synchronized and debounced inside the block. A three-bit sticky cause register records which sources have been active since it was last cleared, so that software can see why the system was reset.

The synchronous active-low `rst_n` stands for the block's own power-good start-up. It puts the block into the held state, so an initial hold period always follows.

Top module: `svr_top`

## Requirements
- R1: While `main_ok` is low, `sys_rst` is high in the same cycle, with no register in the path.
- R2: When the last active cause (`main_ok` low or debounced manual press) releases, `sys_rst` stays high for exactly H clock edges. Counting the first rising edge after the release as edge 1, `sys_rst` goes low right after edge H.
- R3: `hold_sel` picks H. Code 00 gives 2^HOLD_LOG2_A, 01 gives 2^HOLD_LOG2_B and 10 gives 2^HOLD_LOG2_C. With code 11 there is no stretch, and `sys_rst` drops in the same cycle the cause releases.
- R4: After `rst_n` is released with `main_ok` high, `sys_rst` stays high for H edges as in R2.
- R5: A new cause that appears during a hold period restarts the hold. The full H edges are counted again from the new release.
- R6: `mr_n_raw` is synchronized by two flops and then accepted only after 2^DB_LOG2 consecutive cycles at the new level. A press therefore raises `sys_rst` 2^DB_LOG2+2 negedge samples after the pin falls. A pulse shorter than 2^DB_LOG2 cycles has no effect.
- R7: A manual press keeps `sys_rst` high while the pin is low, and for H edges after the debounced release. This gives 2^DB_LOG2+H+2 samples from the pin rising to `sys_rst` low.
- R8: `early_low_n` equals `main_ok` in every cycle, with no hold delay.
- R9: `aux1_fail_n` and `aux2_fail_n` equal `aux1_ok` and `aux2_ok` with no delay. An auxiliary fail never asserts `sys_rst`.
- R10: `sys_rst_n` is always the complement of `sys_rst`.
- R11: `fault_cause` bit 0 records a main-supply drop, bit 1 a debounced manual press and bit 2 either auxiliary fail. Each bit is set on the edge after its source is seen active and then stays set. `fault_clr` clears all three bits on the next edge, except that a source active in that cycle keeps its bit set. `rst_n` low clears the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low start-up reset |
| main_ok | input | 1 | Main supply above its trip point |
| aux1_ok | input | 1 | First auxiliary supply above its trip point |
| aux2_ok | input | 1 | Second auxiliary supply above its trip point |
| mr_n_raw | input | 1 | Raw push-button pin, low when pressed |
| hold_sel | input | 2 | Hold time select (00/01/10, 11 = no stretch) |
| fault_clr | input | 1 | Single-cycle clear strobe for the cause register |
| sys_rst | output | 1 | Active-high system reset |
| sys_rst_n | output | 1 | Active-low system reset |
| early_low_n | output | 1 | Undelayed main supply flag |
| aux1_fail_n | output | 1 | Undelayed first auxiliary fail, low on fail |
| aux2_fail_n | output | 1 | Undelayed second auxiliary fail, low on fail |
| fault_cause | output | 3 | Sticky cause bits {aux, manual, main} |

## Verification
The assertions check three things on every cycle. First, an enabled cause always arms the hold on the next edge, and the hold only ends after a cycle in which no enabled cause was present. Second, the debounced level only ever takes the value the synchronizer showed one cycle earlier. Third, the cause bits are sticky and set by their sources. The exact cycle counts can only be shown by the bench scenarios: hold lengths for each select code, debounce latency, restart of the hold by a mid-hold dip, and rejection of short glitches. The bench measures each of these at the ports.

// File: rtl/svr_pkg.sv
// Package: shared encodings for the supervisor reset generator.
// Assumes: hold_sel codes are fixed by the top-level port contract.
package svr_pkg;

    typedef enum logic [1:0] {
        HOLD_SHORT = 2'b00,
        HOLD_MID   = 2'b01,
        HOLD_LONG  = 2'b10,
        HOLD_OFF   = 2'b11
    } hold_sel_e;

    localparam int CAUSE_MAIN = 0;
    localparam int CAUSE_MAN  = 1;
    localparam int CAUSE_AUX  = 2;
    localparam int CAUSE_W    = 3;

endpackage

// File: rtl/svr_debounce.sv
// Module: svr_debounce
// Synchronizes an asynchronous active-low button pin with two flops.
// It accepts a new level only after the synchronized pin has held it
// for 2^DB_LOG2 consecutive cycles.
// Assumes: the released (high) level is the start-up value.
module svr_debounce #(
    parameter int DB_LOG2 = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o
);
    localparam int CW = (DB_LOG2 < 1) ? 1 : DB_LOG2;
    localparam logic [CW-1:0] LAST = {CW{1'b1}};

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          level_q;

    // Two-flop synchronizer for the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], raw_i};
    end

    // Stability counter; the level is taken when the counter completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            level_q <= 1'b1;
        end else if (sync_q[1] == level_q) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q   <= '0;
            level_q <= sync_q[1];
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign level_o = level_q;

    // R6: an accepted level is always the one the synchronizer showed.
    assert_level_from_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_q) |-> ($past(sync_q[1]) == level_q));

endmodule

// File: rtl/svr_hold_timer.sv
// Module: svr_hold_timer
// Stretches a cause signal. held_o rises on the edge after the cause
// is seen and falls after the cause has been absent for the selected
// number of edges.
// Assumes: all LOG parameters are between 1 and 31; code HOLD_OFF
// disables the stretch.
module svr_hold_timer
    import svr_pkg::*;
#(
    parameter int LOG_A = 12,
    parameter int LOG_B = 16,
    parameter int LOG_C = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cause_i,
    input  logic [1:0] sel_i,
    output logic       held_o
);
    localparam int MAX_AB = (LOG_A > LOG_B) ? LOG_A : LOG_B;
    localparam int CW     = (MAX_AB > LOG_C) ? MAX_AB : LOG_C;
    localparam logic [CW-1:0] LAST_A = CW'((64'd1 << LOG_A) - 64'd1);
    localparam logic [CW-1:0] LAST_B = CW'((64'd1 << LOG_B) - 64'd1);
    localparam logic [CW-1:0] LAST_C = CW'((64'd1 << LOG_C) - 64'd1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_cnt;
    logic          held_q;
    logic          en;

    // Decode the select into the final count value.
    always_comb begin
        en = 1'b1;
        unique case (hold_sel_e'(sel_i))
            HOLD_SHORT: last_cnt = LAST_A;
            HOLD_MID:   last_cnt = LAST_B;
            HOLD_LONG:  last_cnt = LAST_C;
            default: begin
                last_cnt = LAST_A;
                en       = 1'b0;
            end
        endcase
    end

    // Hold state and quiet-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b1;
            cnt_q  <= '0;
        end else if (!en) begin
            held_q <= 1'b0;
            cnt_q  <= '0;
        end else if (cause_i) begin
            held_q <= 1'b1;
            cnt_q  <= '0;
        end else if (held_q) begin
            if (cnt_q == last_cnt) begin
                held_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign held_o = held_q;

    // R2: an enabled cause always arms the hold on the next edge.
    assert_hold_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_i && en) |=> held_q);

    // R5: the hold never ends in a cycle where an enabled cause was seen.
    assert_hold_ends_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(held_q) |-> $past(!cause_i || !en));

endmodule

// File: rtl/svr_fault_log.sv
// Module: svr_fault_log
// Sticky record of which reset causes have been active. A clear
// strobe empties it, but a cause that is active in the same cycle
// keeps its bit.
// Assumes: each source bit is a synchronous level.
module svr_fault_log
    import svr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic [CAUSE_W-1:0] src_i,
    output logic [CAUSE_W-1:0] cause_o
);
    logic [CAUSE_W-1:0] cause_q;

    // Accumulate active sources; clear takes effect below the set.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (clr_i ? '0 : cause_q) | src_i;
    end

    assign cause_o = cause_q;

    for (genvar b = 0; b < CAUSE_W; b++) begin : g_bit_chk
        // R11: an active source is recorded on the next edge.
        assert_src_recorded_R11: assert property (@(posedge clk) disable iff (!rst_n)
            src_i[b] |=> cause_q[b]);
        // R11: a recorded bit stays set unless cleared.
        assert_bit_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(cause_q[b]) && !$past(clr_i)) |-> cause_q[b]);
    end

endmodule

// File: rtl/svr_top.sv
// Module: svr_top
// Supervisor reset generator. It combines a main supply flag and a
// debounced push-button into one reset, stretches that reset by a
// selectable hold, passes the supply flags through undelayed and logs
// the causes.
// Assumes: supply flags are already synchronous to clk.
module svr_top
    import svr_pkg::*;
#(
    parameter int DB_LOG2     = 10,
    parameter int HOLD_LOG2_A = 12,
    parameter int HOLD_LOG2_B = 16,
    parameter int HOLD_LOG2_C = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       main_ok,
    input  logic       aux1_ok,
    input  logic       aux2_ok,
    input  logic       mr_n_raw,
    input  logic [1:0] hold_sel,
    input  logic       fault_clr,
    output logic       sys_rst,
    output logic       sys_rst_n,
    output logic       early_low_n,
    output logic       aux1_fail_n,
    output logic       aux2_fail_n,
    output logic [2:0] fault_cause
);
    logic               mr_level;
    logic               mr_active;
    logic               main_fault;
    logic               cause_any;
    logic               held;
    logic [CAUSE_W-1:0] src_vec;

    svr_debounce #(.DB_LOG2(DB_LOG2)) u_debounce (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (mr_n_raw),
        .level_o (mr_level)
    );

    // Combine the reset causes.
    always_comb begin
        mr_active  = ~mr_level;
        main_fault = ~main_ok;
        cause_any  = main_fault | mr_active;
    end

    svr_hold_timer #(
        .LOG_A (HOLD_LOG2_A),
        .LOG_B (HOLD_LOG2_B),
        .LOG_C (HOLD_LOG2_C)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_i (cause_any),
        .sel_i   (hold_sel),
        .held_o  (held)
    );

    // Cause vector in the register's bit order.
    always_comb begin
        src_vec             = '0;
        src_vec[CAUSE_MAIN] = main_fault;
        src_vec[CAUSE_MAN]  = mr_active;
        src_vec[CAUSE_AUX]  = ~aux1_ok | ~aux2_ok;
    end

    svr_fault_log u_log (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (fault_clr),
        .src_i   (src_vec),
        .cause_o (fault_cause)
    );

    // Output drive: an immediate cause or the stretch; passthrough flags.
    always_comb begin
        sys_rst     = cause_any | held;
        sys_rst_n   = ~sys_rst;
        early_low_n = main_ok;
        aux1_fail_n = aux1_ok;
        aux2_fail_n = aux2_ok;
    end

endmodule

// File: tb/svr_top_tb_top.sv
// Bench for svr_top with shortened hold and debounce parameters.
module svr_top_tb_top;
    localparam int DB  = 3;
    localparam int LA  = 4;
    localparam int LB  = 5;
    localparam int LC  = 6;
    localparam int NDB = 1 << DB;
    localparam int HA  = 1 << LA;
    localparam int HB  = 1 << LB;
    localparam int HC  = 1 << LC;

    // Vector: {main, aux1, aux2, exp_early, exp_a1f, exp_a2f, exp_rst}, hold off.
    localparam logic [6:0] VEC [8] = '{
        7'b111_111_0, 7'b011_011_1, 7'b101_101_0, 7'b110_110_0,
        7'b001_001_1, 7'b100_100_0, 7'b010_010_1, 7'b111_111_0
    };

    logic       clk = 1'b0;
    logic       rst_n, main_ok, aux1_ok, aux2_ok, mr_n_raw, fault_clr;
    logic [1:0] hold_sel;
    logic       sys_rst, sys_rst_n, early_low_n, aux1_fail_n, aux2_fail_n;
    logic [2:0] fault_cause;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    svr_top #(.DB_LOG2(DB), .HOLD_LOG2_A(LA), .HOLD_LOG2_B(LB), .HOLD_LOG2_C(LC)) dut_i (
        .clk(clk), .rst_n(rst_n), .main_ok(main_ok), .aux1_ok(aux1_ok),
        .aux2_ok(aux2_ok), .mr_n_raw(mr_n_raw), .hold_sel(hold_sel),
        .fault_clr(fault_clr), .sys_rst(sys_rst), .sys_rst_n(sys_rst_n),
        .early_low_n(early_low_n), .aux1_fail_n(aux1_fail_n),
        .aux2_fail_n(aux2_fail_n), .fault_cause(fault_cause)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count negedge samples until sys_rst reaches the wanted level.
    task automatic wait_rst(input logic want, output int n);
        n = 0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            n++;
            if (sys_rst == want) break;
        end
    endtask

    task automatic clear_log();
        @(negedge clk) fault_clr = 1'b1;
        @(negedge clk) fault_clr = 1'b0;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        int hi;
        rst_n = 1'b0; main_ok = 1'b0; aux1_ok = 1'b1; aux2_ok = 1'b1;
        mr_n_raw = 1'b1; fault_clr = 1'b0; hold_sel = 2'b00;
        repeat (3) @(negedge clk);
        check("R1 reset state sys_rst", int'(sys_rst), 1);
        check("R10 reset state sys_rst_n", int'(sys_rst_n), 0);
        check("R11 reset clears causes", int'(fault_cause), 0);
        check("R8 early_low_n low", int'(early_low_n), 0);
        main_ok = 1'b1;
        @(negedge clk) rst_n = 1'b1;
        wait_rst(1'b0, n);
        check("R4 power-up hold", n, HA);
        check("R11 no cause after clean start", int'(fault_cause), 0);

        // R3 R8 R9 R10: vector table with the stretch disabled.
        @(negedge clk) hold_sel = 2'b11;
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            {main_ok, aux1_ok, aux2_ok} = VEC[i][6:4];
            @(negedge clk);
            check("R8 early_low_n", int'(early_low_n), int'(VEC[i][3]));
            check("R9 aux1_fail_n", int'(aux1_fail_n), int'(VEC[i][2]));
            check("R9 aux2_fail_n", int'(aux2_fail_n), int'(VEC[i][1]));
            check("R3 sys_rst no stretch", int'(sys_rst), int'(VEC[i][0]));
            check("R10 complement", int'(sys_rst_n), int'(!sys_rst));
        end
        check("R11 main and aux logged", int'(fault_cause), 5);
        clear_log();
        @(negedge clk);
        check("R11 clear", int'(fault_cause), 0);

        // R3: with code 11 the reset drops as soon as the cause releases.
        main_ok = 1'b0;
        repeat (2) @(negedge clk);
        main_ok = 1'b1;
        wait_rst(1'b0, n);
        check("R3 no-stretch release", n, 1);

        // R1 R2 R3: dips with each stretching code.
        for (int s = 0; s < 3; s++) begin
            @(negedge clk) hold_sel = 2'(s);
            clear_log();
            main_ok = 1'b0;
            #2;
            check("R1 immediate assert", int'(sys_rst), 1);
            repeat (3) @(negedge clk);
            check("R11 main logged", int'(fault_cause), 1);
            main_ok = 1'b1;
            wait_rst(1'b0, n);
            check("R2 hold length", n, (s == 0) ? HA : (s == 1) ? HB : HC);
        end

        // R5: a dip during the hold restarts it.
        @(negedge clk) hold_sel = 2'b00;
        main_ok = 1'b0;
        @(negedge clk) main_ok = 1'b1;
        repeat (10) @(negedge clk);
        main_ok = 1'b0;
        @(negedge clk) main_ok = 1'b1;
        wait_rst(1'b0, n);
        check("R5 restart hold", n, HA);

        // R11: clear during an active source keeps its bit.
        main_ok = 1'b0;
        @(negedge clk) fault_clr = 1'b1;
        @(negedge clk) fault_clr = 1'b0;
        @(negedge clk);
        check("R11 active source survives clear", int'(fault_cause), 1);
        main_ok = 1'b1;
        wait_rst(1'b0, n);
        clear_log();

        // R6: a short glitch is ignored.
        mr_n_raw = 1'b0;
        repeat (NDB - 5) @(negedge clk);
        mr_n_raw = 1'b1;
        hi = 0;
        for (int k = 0; k < 3 * NDB; k++) begin
            @(negedge clk);
            if (sys_rst) hi++;
        end
        check("R6 glitch ignored", hi, 0);
        check("R6 glitch not logged", int'(fault_cause), 0);

        // R6 R7: a real press.
        mr_n_raw = 1'b0;
        wait_rst(1'b1, n);
        check("R6 press latency", n, NDB + 2);
        repeat (20) @(negedge clk);
        check("R7 held while pressed", int'(sys_rst), 1);
        check("R11 manual logged", int'(fault_cause), 2);
        mr_n_raw = 1'b1;
        wait_rst(1'b0, n);
        check("R7 release latency", n, NDB + HA + 2);
        clear_log();

        // R9: an auxiliary fail never resets.
        aux2_ok = 1'b0;
        repeat (HA + 4) @(negedge clk);
        check("R9 aux fail no reset", int'(sys_rst), 0);
        check("R9 aux2_fail_n low", int'(aux2_fail_n), 0);
        check("R11 aux logged", int'(fault_cause), 4);
        aux2_ok = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule